// File: doc/BRIEF.md
# Nibble Accumulator Bank Latch

This block sits on the cartridge side of an 8-bit CPU bus and watches write cycles. Four register slots in a small address window hold a 6-bit working value, a 4-bit staging nibble, an invert flag and a count-mode flag. The first slot acts as an accumulator kick. It either bumps the low nibble of the working value by one, or reloads that nibble from the staging nibble, complemented when the invert flag is set.

Any write that falls outside the window takes a snapshot of the working value into a 6-bit bank latch. The snapshot has its two high bits complemented when invert is set, and the latch drives the bank select lines. The same presented value is available continuously as the readback that CPU reads of the window return.

The write strobe, address and data pins are plain control inputs. They need no back-pressure because every write completes in the cycle it is strobed. Bus timing, the ROM arrays and the nametable mirroring are left to neighbouring logic. The invert flag is brought out for that neighbouring logic.

Top module: `nabl_top`

## Requirements
- R1: With `rst` high at a clock edge, the working value, staging nibble, invert flag, count-mode flag and bank latch all become zero, so `bank_q`, `inv_q` and `rd_val` read 0 after that edge.
- R2: The address is decoded as `wr_addr & 16'hE103`. The results 0x4100, 0x4101, 0x4102 and 0x4103 select slots 0 to 3, so aliases such as 0x4104 and 0x5DFC reach slot 0. Every other result is a latch-update write.
- R3: A slot-0 write with count mode set adds one to working bits 3:0, so 0xF wraps to 0x0, and leaves working bits 5:4 unchanged.
- R4: A slot-0 write with count mode clear loads working bits 3:0 with the staging nibble, XORed with 0xF when the invert flag is 1.
- R5: A slot-1 write sets the invert flag to data bit 0, and `inv_q` shows the flag.
- R6: A slot-2 write puts data bits 5:4 into working bits 5:4 and data bits 3:0 into the staging nibble. It does not change working bits 3:0.
- R7: A slot-3 write sets count mode to data bit 0.
- R8: A latch-update write loads `bank_q` with working bits 3:0 in bits 3:0 and working bits 5:4 XOR {2{invert}} in bits 5:4, using the values held before that edge. No other write and no idle cycle changes `bank_q`.
- R9: `rd_val` always equals {working[5:4] XOR {2{invert}}, working[3:0]} for the current register state.
- R10: State changes only at an edge where `wr_en` is 1. With `wr_en` at 0, the address and data inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 6 | CPU write data bits 5:0 |
| bank_q | output | 6 | Bank select latch |
| inv_q | output | 1 | Invert flag |
| rd_val | output | 6 | Presented value for reads of the register window |

## Verification
The bench sweeps every staging nibble under both invert settings and every slot-2 data pattern. It runs the counter far enough to wrap the nibble. It reaches slot 0 through aliased addresses that only the 0xE103 mask maps into the window, and it also writes an address just below the window that must count as a latch write.

A decoder with the wrong mask would turn aliases into latch writes or miss them. A design that snapshots after the update, or forgets the high-bit complement, would show a `bank_q` that differs from the readback taken before the latch write. A counter that carries into bit 4, or a staging write that leaks into the low nibble before slot 0 is written, would show up at once in `rd_val`.

// File: rtl/nabl_pkg.sv
package nabl_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ACC   = 3'd1,
    OP_INV   = 3'd2,
    OP_STAGE = 3'd3,
    OP_MODE  = 3'd4,
    OP_LATCH = 3'd5
  } op_e;

  localparam int NUM_SLOTS = 4;
endpackage

// File: rtl/nabl_decode.sv
module nabl_decode
  import nabl_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MASK = 16'hE103,
  parameter logic [ADDR_W-1:0] BASE = 16'h4100
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op
);
  logic [ADDR_W-1:0]    masked;
  logic [NUM_SLOTS-1:0] hit;

  assign masked = addr & MASK;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign hit[g] = (masked == (BASE + ADDR_W'(g)));
  end

  always_comb begin
    op = OP_NONE;
    if (wr_en) begin
      if      (hit[0]) op = OP_ACC;
      else if (hit[1]) op = OP_INV;
      else if (hit[2]) op = OP_STAGE;
      else if (hit[3]) op = OP_MODE;
      else             op = OP_LATCH;
    end
  end
endmodule

// File: rtl/nabl_work.sv
module nabl_work
  import nabl_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] work,
  output logic              inv
);
  localparam int HI_W = DATA_W - NIB_W;

  logic [NIB_W-1:0] lo_q, stage_q;
  logic [HI_W-1:0]  hi_q;
  logic             count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      hi_q    <= '0;
      stage_q <= '0;
      inv     <= 1'b0;
      count_q <= 1'b0;
    end else begin
      case (op)
        OP_ACC: begin
          if (count_q) lo_q <= lo_q + NIB_W'(1);
          else         lo_q <= stage_q ^ {NIB_W{inv}};
        end
        OP_INV:   inv <= data[0];
        OP_STAGE: begin
          hi_q    <= data[DATA_W-1:NIB_W];
          stage_q <= data[NIB_W-1:0];
        end
        OP_MODE:  count_q <= data[0];
        default: ;
      endcase
    end
  end

  assign work = {hi_q, lo_q};
endmodule

// File: rtl/nabl_latch.sv
module nabl_latch #(
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] view,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= view;
  end
endmodule

// File: rtl/nabl_top.sv
module nabl_top
  import nabl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 6,
  parameter int NIB_W  = 4,
  parameter logic [ADDR_W-1:0] MASK = 16'hE103,
  parameter logic [ADDR_W-1:0] BASE = 16'h4100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] bank_q,
  output logic              inv_q,
  output logic [DATA_W-1:0] rd_val
);
  localparam int HI_W = DATA_W - NIB_W;

  op_e               op;
  logic [DATA_W-1:0] work;
  logic [DATA_W-1:0] view;

  nabl_decode #(.ADDR_W(ADDR_W), .MASK(MASK), .BASE(BASE)) u_dec (
    .wr_en (wr_en),
    .addr  (wr_addr),
    .op    (op)
  );

  nabl_work #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_work (
    .clk  (clk),
    .rst  (rst),
    .op   (op),
    .data (wr_data),
    .work (work),
    .inv  (inv_q)
  );

  assign view = {work[DATA_W-1:NIB_W] ^ {HI_W{inv_q}}, work[NIB_W-1:0]};

  nabl_latch #(.DATA_W(DATA_W)) u_latch (
    .clk  (clk),
    .rst  (rst),
    .load (op == OP_LATCH),
    .view (view),
    .q    (bank_q)
  );

  assign rd_val = view;
endmodule

// File: rtl/nabl_chk.sv
module nabl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 6,
  parameter int NIB_W  = 4,
  parameter logic [ADDR_W-1:0] MASK = 16'hE103,
  parameter logic [ADDR_W-1:0] BASE = 16'h4100
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] bank_q,
  input logic              inv_q,
  input logic [DATA_W-1:0] rd_val
);
  logic [ADDR_W-1:0] dec;
  logic              in_win;

  assign dec    = wr_addr & MASK;
  assign in_win = (dec >= BASE) && (dec <= BASE + ADDR_W'(3));

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (bank_q == '0 && rd_val == '0 && !inv_q));

  // R8
  latch_snapshot_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_win) |=> (bank_q == $past(rd_val)));

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !in_win) |=> $stable(bank_q));

  // R5
  invert_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dec == BASE + ADDR_W'(1)) |=> (inv_q == $past(wr_data[0])));

  // R6
  stage_high_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dec == BASE + ADDR_W'(2)) |=>
      (rd_val[DATA_W-1:NIB_W] == ($past(wr_data[DATA_W-1:NIB_W]) ^ {(DATA_W-NIB_W){inv_q}})
       && rd_val[NIB_W-1:0] == $past(rd_val[NIB_W-1:0])));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(rd_val) && $stable(inv_q)));
endmodule

bind nabl_top nabl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NIB_W(NIB_W), .MASK(MASK), .BASE(BASE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .bank_q(bank_q), .inv_q(inv_q), .rd_val(rd_val)
);

// File: tb/sim_nabl_top.sv
`timescale 1ns/1ps
module sim_nabl_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [5:0]  wr_data = '0;
  logic [5:0]  bank_q, rd_val;
  logic        inv_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [5:0] m_w = '0;
  logic [3:0] m_stg = '0;
  logic       m_inv = 0;
  logic       m_inc = 0;
  logic [5:0] m_out = '0;

  always #2 clk = ~clk;

  nabl_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank_q(bank_q), .inv_q(inv_q), .rd_val(rd_val)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] m_view();
    return {m_w[5:4] ^ {2{m_inv}}, m_w[3:0]};
  endfunction

  task automatic compare(string req);
    check(req, "rd_val", rd_val, m_view());
    check(req, "inv_q",  inv_q,  m_inv);
    check(req, "bank_q", bank_q, m_out);
  endtask

  task automatic wr(string req, logic [15:0] a, logic [5:0] d);
    logic [15:0] da;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    da = a & 16'hE103;
    case (da)
      16'h4100: if (m_inc) m_w[3:0] = m_w[3:0] + 4'd1;
                else       m_w[3:0] = m_stg ^ {4{m_inv}};
      16'h4101: m_inv = d[0];
      16'h4102: begin m_w[5:4] = d[5:4]; m_stg = d[3:0]; end
      16'h4103: m_inc = d[0];
      default:  m_out = m_view();
    endcase
    compare(req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    compare("R1");

    // R10 address and data without strobe are ignored
    wr_addr = 16'h4101; wr_data = 6'h3F;
    repeat (3) @(negedge clk);
    compare("R10");
    wr_addr = 16'h8000;
    repeat (2) @(negedge clk);
    compare("R10");

    // R4 R6 R8 R9: every staging nibble under both invert settings
    for (int iv = 0; iv < 2; iv++) begin
      for (int s = 0; s < 16; s++) begin
        wr("R5", 16'h4101, 6'(iv));
        wr("R6", 16'h4102, 6'((s * 5 + iv) & 6'h30) | 6'(s));
        wr("R4", 16'h4100, 6'h00);
        wr("R8", 16'h8000, 6'h00);
      end
    end

    // R7 R3 R2: count mode, wrap, aliased addresses, latch every few
    wr("R7", 16'h4103, 6'h01);
    wr("R6", 16'h4102, 6'h2E);
    for (int k = 0; k < 20; k++) begin
      case (k % 3)
        0: wr("R3", 16'h4100, 6'h00);
        1: wr("R2", 16'h4104, 6'h00);
        default: wr("R2", 16'h5DFC, 6'h00);
      endcase
      if (k % 4 == 3) wr("R8", (k % 8 == 3) ? 16'hC000 : 16'h4000, 6'h00);
    end
    wr("R5", 16'h4101, 6'h01);
    wr("R3", 16'h4100, 6'h00);
    wr("R8", 16'h40FF, 6'h00);

    // R7 back to load mode
    wr("R7", 16'h4103, 6'h00);
    wr("R4", 16'h4100, 6'h00);

    // R9 R6: every slot-2 data pattern, invert alternating
    for (int d = 0; d < 64; d++) begin
      wr("R5", 16'h4101, 6'(d >> 2));
      wr("R9", 16'h4102, 6'(d));
      if (d % 8 == 0) wr("R8", 16'hFFFF, 6'h15);
    end

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_w = '0; m_stg = '0; m_inv = 0; m_inc = 0; m_out = '0;
    compare("R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule